// File: doc/BRIEF.md
# Transceiver Lane-Rate Reconfiguration Sequencer

This block retunes a four-lane serial transceiver link between two lane-rate groups: a low group of two neighbouring rates (near 2.46 and 2.5 Gbps) and a single high rate (3.072 Gbps). The rates inside the low group share every transceiver setting. On a start pulse it compares the requested rate code with the rate it last programmed. If both lie in the same group, and no forced run is asked for, it skips all register traffic. Otherwise it rewrites the shared PLL fields and then the fields of each lane. All register traffic goes through a 16-bit dynamic-reconfiguration port that has an address, write data, read data, an enable, a write flag and a ready return.

The order of work is fixed. First the shared PLL registers are written. Then the PLL reset is pulsed and the sequencer waits for lock. Then the registers of each lane are written in turn. Then the lane reset is pulsed and the sequencer waits for reset-done. The two reset-and-wait steps run even when the register writes are skipped. Fields that share a register with other settings are read, merged under a fixed keep mask and written back. If a wait runs past a programmable number of cycles, the run ends with an error, and the stored rate keeps its old value.

Top module: `drp_rate_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `err`, `cur_valid`, `drp_en`, `pll_rst` and `lane_rst` are 0, and `tgt_sel` is 0.
- R2: Rate codes with bit 1 clear (0, 1) form the low group, and codes with bit 1 set (2, 3) form the high group. A start with `force_full` low, `cur_valid` high and a request in the same group as `cur_rate` makes no port transaction. Any other start makes the full rewrite: 43 writes and 10 reads.
- R3: PLL address 0x32 receives config bits [15:0]. Address 0x33 is read, and then written with its bits under mask 0xF800 kept and config bits [26:16] in bits [10:0]. The config is 0x0680181 for the low group and 0x06801C1 for the high group.
- R4: PLL address 0x36 is read, and then written with bits under mask 0xFC00 kept and the feedback divider in bits [9:0]. The divider is 0x120 for the low group and 0x080 for the high group.
- R5: Order: PLL transactions, then one `pll_rst` pulse and the wait for `pll_lock`, then lane transactions, then one `lane_rst` pulse and the wait for `lane_rst_done`. Both pulses occur on skipped runs too.
- R6: Each lane gets the 32-bit PMA value with its low half at 0x99 and its high half at 0x9A. The value is 0x001E7080 for the low group and 0x00018480 for the high group.
- R7: The receive 25 MHz divider minus one is merged into bits [10:6] of 0x11 under keep mask 0xF83F. The transmit one is merged into bits [4:0] of 0x6A under keep mask 0xFFE0. The divider is 5 for the low group and 7 for the high group.
- R8: The 80-bit CDR config goes to 0xA8 through 0xAC, least significant word first. The low group value is 0x03000023FF10100020 and the high group value is 0x03000023FF10200020.
- R9: Address 0x88 is written whole. Bits [2:0] hold log2 of the receive output divider and bits [6:4] hold log2 of the transmit one. The divider is 4 for the low group and 2 for the high group, which gives 0x0022 and 0x0011.
- R10: `tgt_sel` is 1 during PLL transactions, 2+k during the transactions of lane k, and 0 at all other times, including after the last lane.
- R11: Each transaction raises `drp_en` for exactly one cycle. The next one does not start until `drp_rdy` has returned. Read data is captured on `drp_rdy` and used for the merge.
- R12: If the lock or reset-done wait lasts beyond `wait_limit` cycles, `err` is set, the run ends, and `cur_rate`/`cur_valid` are left unchanged.
- R13: A successful run sets `done`, stores the requested code in `cur_rate` and sets `cur_valid`. `done` and `err` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; ignored while busy |
| rate_req | input | 2 | Requested rate code |
| force_full | input | 1 | Rewrite even if the groups match |
| wait_limit | input | TW | Cycle limit for the lock and reset-done waits |
| drp_en | output | 1 | Transaction strobe |
| drp_we | output | 1 | 1 = write, 0 = read |
| drp_addr | output | AW | Register address |
| drp_wdata | output | 16 | Write data |
| drp_rdata | input | 16 | Read data |
| drp_rdy | input | 1 | Transaction complete |
| tgt_sel | output | SW | 0 none, 1 PLL, 2+k lane k |
| pll_rst | output | 1 | One-cycle PLL reset pulse |
| pll_lock | input | 1 | PLL locked |
| lane_rst | output | 1 | One-cycle lane reset pulse |
| lane_rst_done | input | 1 | Lane reset finished |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run succeeded |
| err | output | 1 | Last run timed out |
| cur_valid | output | 1 | `cur_rate` holds a programmed rate |
| cur_rate | output | 2 | Last successfully programmed code |

## Verification
The embedded properties check the handshake and ordering rules on every cycle. These are the one-cycle enable, an enable only with a target selected, a target that never returns from lane to PLL within a run, single-cycle reset pulses, `done` and `err` never high together, and a stored rate that holds when an error rises. Field contents, keep-mask preservation, the skip decision across a series of rate changes, and the timeout paths can only be shown by the bench scenarios. The bench does this by comparing a modelled register file against values derived from the requirements.

// File: rtl/drp_rate_seq.sv
module drp_rate_seq #(
  parameter int AW = 9,
  parameter int TW = 16,
  parameter int LANES = 4,
  parameter logic [26:0] PLL_CFG_LO = 27'h0680181,
  parameter logic [26:0] PLL_CFG_HI = 27'h06801C1,
  parameter logic [9:0]  FBDIV_LO = 10'h120,
  parameter logic [9:0]  FBDIV_HI = 10'h080,
  parameter logic [31:0] PMA_LO = 32'h001E7080,
  parameter logic [31:0] PMA_HI = 32'h00018480,
  parameter int CLK25_LO = 5,
  parameter int CLK25_HI = 7,
  parameter int OUTDIV_LO = 4,
  parameter int OUTDIV_HI = 2,
  parameter logic [79:0] CDR_LO = 80'h03000023FF10100020,
  parameter logic [79:0] CDR_HI = 80'h03000023FF10200020
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    rate_req,
  input  logic          force_full,
  input  logic [TW-1:0] wait_limit,
  output logic          drp_en,
  output logic          drp_we,
  output logic [AW-1:0] drp_addr,
  output logic [15:0]   drp_wdata,
  input  logic [15:0]   drp_rdata,
  input  logic          drp_rdy,
  output logic [$clog2(LANES+2)-1:0] tgt_sel,
  output logic          pll_rst,
  input  logic          pll_lock,
  output logic          lane_rst,
  input  logic          lane_rst_done,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          cur_valid,
  output logic [1:0]    cur_rate
);
  localparam int SW = $clog2(LANES+2);
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [4:0] C25_LO = 5'(CLK25_LO - 1);
  localparam logic [4:0] C25_HI = 5'(CLK25_HI - 1);
  localparam logic [2:0] LOG_LO = 3'($clog2(OUTDIV_LO));
  localparam logic [2:0] LOG_HI = 3'($clog2(OUTDIV_HI));

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_PRST, S_PWAIT, S_LRST, S_LWAIT} st_t;

  st_t st;
  logic in_lane, hi, skip_q;
  logic [3:0] op;
  logic [LW-1:0] lane;
  logic [15:0] rdq;
  logic [1:0] req_q;
  logic [TW-1:0] wcnt;
  logic op_we, op_last;
  logic [AW-1:0] op_addr;
  logic [15:0] op_data;

  wire [26:0] pll_cfg = hi ? PLL_CFG_HI : PLL_CFG_LO;
  wire [9:0]  fbdiv   = hi ? FBDIV_HI : FBDIV_LO;
  wire [31:0] pma     = hi ? PMA_HI : PMA_LO;
  wire [4:0]  c25     = hi ? C25_HI : C25_LO;
  wire [2:0]  odl     = hi ? LOG_HI : LOG_LO;
  wire [79:0] cdr     = hi ? CDR_HI : CDR_LO;
  wire [2:0]  cdr_idx = 3'(op - 4'd6);
  wire        skip_now = !force_full && cur_valid && (cur_rate[1] == rate_req[1]);

  always_comb begin
    op_we = 1'b1;
    op_last = 1'b0;
    op_addr = '0;
    op_data = '0;
    if (!in_lane) begin
      case (op)
        4'd0: begin op_addr = AW'(9'h032); op_data = pll_cfg[15:0]; end
        4'd1: begin op_addr = AW'(9'h033); op_we = 1'b0; end
        4'd2: begin op_addr = AW'(9'h033); op_data = (rdq & 16'hF800) | {5'd0, pll_cfg[26:16]}; end
        4'd3: begin op_addr = AW'(9'h036); op_we = 1'b0; end
        default: begin
          op_addr = AW'(9'h036);
          op_data = (rdq & 16'hFC00) | {6'd0, fbdiv};
          op_last = 1'b1;
        end
      endcase
    end else begin
      case (op)
        4'd0: begin op_addr = AW'(9'h099); op_data = pma[15:0]; end
        4'd1: begin op_addr = AW'(9'h09A); op_data = pma[31:16]; end
        4'd2: begin op_addr = AW'(9'h011); op_we = 1'b0; end
        4'd3: begin op_addr = AW'(9'h011); op_data = (rdq & 16'hF83F) | {5'd0, c25, 6'd0}; end
        4'd4: begin op_addr = AW'(9'h06A); op_we = 1'b0; end
        4'd5: begin op_addr = AW'(9'h06A); op_data = (rdq & 16'hFFE0) | {11'd0, c25}; end
        4'd6, 4'd7, 4'd8, 4'd9, 4'd10: begin
          op_addr = AW'(9'h0A8) + AW'(cdr_idx);
          op_data = cdr[16*cdr_idx +: 16];
        end
        default: begin
          op_addr = AW'(9'h088);
          op_data = {9'd0, odl, 1'b0, odl};
          op_last = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      in_lane <= 1'b0;
      hi <= 1'b0;
      skip_q <= 1'b0;
      op <= '0;
      lane <= '0;
      rdq <= '0;
      req_q <= '0;
      wcnt <= '0;
      done <= 1'b0;
      err <= 1'b0;
      cur_valid <= 1'b0;
      cur_rate <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          req_q <= rate_req;
          hi <= rate_req[1];
          skip_q <= skip_now;
          done <= 1'b0;
          err <= 1'b0;
          in_lane <= 1'b0;
          op <= '0;
          lane <= '0;
          st <= skip_now ? S_PRST : S_ISSUE;
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (drp_rdy) begin
          if (!op_we) rdq <= drp_rdata;
          if (!op_last) begin
            op <= op + 4'd1;
            st <= S_ISSUE;
          end else if (!in_lane) begin
            st <= S_PRST;
          end else if (lane == LW'(LANES-1)) begin
            st <= S_LRST;
          end else begin
            lane <= lane + LW'(1);
            op <= '0;
            st <= S_ISSUE;
          end
        end
        S_PRST: begin
          wcnt <= '0;
          st <= S_PWAIT;
        end
        S_PWAIT: if (pll_lock) begin
          in_lane <= 1'b1;
          op <= '0;
          lane <= '0;
          st <= skip_q ? S_LRST : S_ISSUE;
        end else if (wcnt >= wait_limit) begin
          err <= 1'b1;
          st <= S_IDLE;
        end else begin
          wcnt <= wcnt + TW'(1);
        end
        S_LRST: begin
          wcnt <= '0;
          st <= S_LWAIT;
        end
        S_LWAIT: if (lane_rst_done) begin
          done <= 1'b1;
          cur_rate <= req_q;
          cur_valid <= 1'b1;
          st <= S_IDLE;
        end else if (wcnt >= wait_limit) begin
          err <= 1'b1;
          st <= S_IDLE;
        end else begin
          wcnt <= wcnt + TW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  wire xfer = (st == S_ISSUE) || (st == S_WAIT);
  assign drp_en    = (st == S_ISSUE);
  assign drp_we    = op_we;
  assign drp_addr  = op_addr;
  assign drp_wdata = op_data;
  assign tgt_sel   = !xfer ? '0 : (in_lane ? SW'(lane) + SW'(2) : SW'(1));
  assign pll_rst   = (st == S_PRST);
  assign lane_rst  = (st == S_LRST);
  assign busy      = (st != S_IDLE);

  AST_EN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) drp_en |=> !drp_en); // R11
  AST_EN_HAS_TARGET: assert property (@(posedge clk) disable iff (!rst_n) drp_en |-> (tgt_sel != '0)); // R10
  AST_PLL_BEFORE_LANE: assert property (@(posedge clk) disable iff (!rst_n) (tgt_sel >= SW'(2)) |=> (tgt_sel != SW'(1))); // R5
  AST_PLL_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n) pll_rst |=> !pll_rst); // R5
  AST_LANE_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n) lane_rst |=> !lane_rst); // R5
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done && err)); // R13
  AST_RATE_HOLD_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n) $rose(err) |-> ($stable(cur_rate) && $stable(cur_valid))); // R12
  AST_DONE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> cur_valid); // R13
endmodule

// File: tb/drp_rate_seq_tb.sv
module drp_rate_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LOCK_DLY = 5;
  localparam int RDY_DLY = 3;
  // row = {rate[1:0], force, expect_full}
  localparam logic [3:0] VEC [0:5] = '{4'b0001, 4'b0100, 4'b1001, 4'b1100, 4'b0001, 4'b0011};

  logic clk = 0, rst_n = 0, start = 0, force_full = 0;
  logic [1:0] rate_req = 0;
  logic [15:0] wait_limit = 16'd20;
  logic drp_en, drp_we, drp_rdy = 0, pll_rst, lane_rst, busy, done, err, cur_valid;
  logic [8:0] drp_addr;
  logic [15:0] drp_wdata, drp_rdata = 0;
  logic [2:0] tgt_sel;
  logic pll_lock = 1, lane_rst_done = 1, lock_en = 1, rdone_en = 1;
  logic [1:0] cur_rate;

  int total = 0, fails = 0;
  int nw = 0, nr = 0, np = 0, nl = 0, order_bad = 0, hs_bad = 0;
  int lat = 0, lcnt = 0, dcnt = 0;
  logic seen_prst = 0, lock_ok = 0;
  logic [2:0] tq;
  logic [7:0] aq;
  logic [15:0] rf [0:5][0:255];

  always #(CLK_PERIOD/2) clk = ~clk;

  drp_rate_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rate_req(rate_req), .force_full(force_full),
    .wait_limit(wait_limit), .drp_en(drp_en), .drp_we(drp_we), .drp_addr(drp_addr),
    .drp_wdata(drp_wdata), .drp_rdata(drp_rdata), .drp_rdy(drp_rdy), .tgt_sel(tgt_sel),
    .pll_rst(pll_rst), .pll_lock(pll_lock), .lane_rst(lane_rst), .lane_rst_done(lane_rst_done),
    .busy(busy), .done(done), .err(err), .cur_valid(cur_valid), .cur_rate(cur_rate));

  function automatic logic [15:0] init_val(int t, int a);
    return 16'(a * 997) ^ 16'(t * 4099) ^ 16'hC35A;
  endfunction

  // transceiver model and monitor
  always @(posedge clk) begin
    drp_rdy <= 1'b0;
    if (start && !busy) begin seen_prst = 0; lock_ok = 0; end
    if (pll_rst) begin seen_prst = 1; np++; end
    if (lane_rst) begin nl++; if (!lock_ok) order_bad++; end
    if (seen_prst && pll_lock) lock_ok = 1;
    if (drp_en) begin
      if (lat != 0) hs_bad++;
      if (tgt_sel == 0) order_bad++;
      if (tgt_sel == 1 && seen_prst) order_bad++;
      if (tgt_sel >= 2 && !lock_ok) order_bad++;
      if (drp_we) begin nw++; rf[tgt_sel][drp_addr[7:0]] = drp_wdata; end
      else nr++;
      tq = tgt_sel; aq = drp_addr[7:0]; lat = RDY_DLY;
    end else if (lat != 0) begin
      lat = lat - 1;
      if (lat == 0) begin drp_rdy <= 1'b1; drp_rdata <= rf[tq][aq]; end
    end
    if (pll_rst) begin pll_lock <= 1'b0; lcnt = LOCK_DLY; end
    else if (lcnt != 0) begin lcnt = lcnt - 1; if (lcnt == 0 && lock_en) pll_lock <= 1'b1; end
    if (lane_rst) begin lane_rst_done <= 1'b0; dcnt = LOCK_DLY; end
    else if (dcnt != 0) begin dcnt = dcnt - 1; if (dcnt == 0 && rdone_en) lane_rst_done <= 1'b1; end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] r, input logic f, output int dw, output int dr, output int dp, output int dl);
    int w0, r0, p0, l0;
    bit fin;
    w0 = nw; r0 = nr; p0 = np; l0 = nl;
    @(negedge clk);
    rate_req = r; force_full = f; start = 1;
    @(negedge clk);
    start = 0;
    fin = 0;
    for (int i = 0; i < 5000 && !fin; i++) begin
      @(negedge clk);
      if (!busy && (done || err)) fin = 1;
    end
    chk("R13 run completes", 32'(fin), 1);
    dw = nw - w0; dr = nr - r0; dp = np - p0; dl = nl - l0;
  endtask

  task automatic check_regs(input logic hi);
    chk("R3 pll 0x32", 32'(rf[1][8'h32]), hi ? 32'h01C1 : 32'h0181);
    chk("R3 pll 0x33 merge", 32'(rf[1][8'h33]), 32'((init_val(1, 8'h33) & 16'hF800) | 16'h0068));
    chk("R4 pll 0x36 merge", 32'(rf[1][8'h36]), 32'((init_val(1, 8'h36) & 16'hFC00) | (hi ? 16'h0080 : 16'h0120)));
    for (int t = 2; t < 6; t++) begin
      chk("R6 pma low", 32'(rf[t][8'h99]), hi ? 32'h8480 : 32'h7080);
      chk("R6 pma high", 32'(rf[t][8'h9A]), hi ? 32'h0001 : 32'h001E);
      chk("R7 rx clk25", 32'(rf[t][8'h11]), 32'((init_val(t, 8'h11) & 16'hF83F) | (hi ? 16'h0180 : 16'h0100)));
      chk("R7 tx clk25", 32'(rf[t][8'h6A]), 32'((init_val(t, 8'h6A) & 16'hFFE0) | (hi ? 16'h0006 : 16'h0004)));
      chk("R8 cdr w0", 32'(rf[t][8'hA8]), 32'h0020);
      chk("R8 cdr w1", 32'(rf[t][8'hA9]), hi ? 32'h1020 : 32'h1010);
      chk("R8 cdr w2", 32'(rf[t][8'hAA]), 32'h23FF);
      chk("R8 cdr w3", 32'(rf[t][8'hAB]), 32'h0000);
      chk("R8 cdr w4", 32'(rf[t][8'hAC]), 32'h0003);
      chk("R9 outdiv 0x88", 32'(rf[t][8'h88]), hi ? 32'h0011 : 32'h0022);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int dw, dr, dp, dl;
    for (int t = 0; t < 6; t++)
      for (int a = 0; a < 256; a++) rf[t][a] = init_val(t, a);
    repeat (3) @(negedge clk);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done/err", 32'({done, err}), 0);
    chk("R1 cur_valid", 32'(cur_valid), 0);
    chk("R1 strobes", 32'({drp_en, pll_rst, lane_rst}), 0);
    chk("R1 tgt_sel", 32'(tgt_sel), 0);
    rst_n = 1;

    for (int v = 0; v < 6; v++) begin
      run(VEC[v][3:2], VEC[v][1], dw, dr, dp, dl);
      chk("R13 done", 32'({done, err}), 32'b10);
      chk("R13 cur_rate", 32'({cur_valid, cur_rate}), 32'({1'b1, VEC[v][3:2]}));
      chk("R2 writes", 32'(dw), VEC[v][0] ? 43 : 0);
      chk("R2 reads", 32'(dr), VEC[v][0] ? 10 : 0);
      chk("R5 pll pulses", 32'(dp), 1);
      chk("R5 lane pulses", 32'(dl), 1);
      chk("R10 tgt idle", 32'(tgt_sel), 0);
      if (VEC[v][0]) check_regs(VEC[v][3]);
    end
    chk("R5 R10 order", 32'(order_bad), 0);
    chk("R11 handshake", 32'(hs_bad), 0);

    lock_en = 0;
    run(2'd2, 1'b1, dw, dr, dp, dl);
    chk("R12 lock timeout err", 32'({done, err}), 32'b01);
    chk("R12 rate kept", 32'({cur_valid, cur_rate}), 32'b100);
    chk("R12 only pll traffic", 32'(dw + dr), 5);
    chk("R12 no lane reset", 32'(dl), 0);
    lock_en = 1;

    rdone_en = 0;
    run(2'd2, 1'b1, dw, dr, dp, dl);
    chk("R12 reset-done timeout err", 32'({done, err}), 32'b01);
    chk("R12 rate kept 2", 32'({cur_valid, cur_rate}), 32'b100);
    chk("R12 full traffic", 32'(dw), 43);
    rdone_en = 1;
    repeat (10) @(negedge clk);

    run(2'd1, 1'b0, dw, dr, dp, dl);
    chk("R2 skip after errors", 32'(dw + dr), 0);
    chk("R13 cur after skip", 32'({done, cur_rate}), 32'b101);
    chk("R11 handshake end", 32'(hs_bad), 0);
    chk("R5 order end", 32'(order_bad), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule